// File: doc/BRIEF.md
# Frame-Locked Stream Demultiplexer

This block takes one ready/valid byte stream and steers each frame to one of four downstream streams. A small destination input picks the output. The choice is fixed when the first beat of a frame is accepted and holds until the beat that carries the end-of-frame flag is accepted. A frame therefore always lands whole on a single output, even if the destination input moves while the frame is in flight.

The path is purely combinational, with no storage on the data path. Data, end-of-frame and the side-band user bit reach the routed output in the same cycle they are offered. Only the routed output sees valid high. Its ready flows straight back to the source, so each output can throttle its own frames. The only state is a frame-in-progress flag and the locked destination.

Top module: `frame_demux`

## Requirements
- R1: When no frame is in progress and the input offers a beat, output n (n = value of `sel`, 0 to 3) shows valid high for that beat.
- R2: At most one output valid is high in any cycle, and all output valids are low while input valid is low.
- R3: The routed output carries the input data, end-of-frame and user bit unchanged in the same cycle they are offered.
- R4: The destination is captured when the first beat of a frame is accepted. Changes of `sel` afterwards do not move the rest of the frame.
- R5: `in_ready` equals the ready of the routed output. While that ready is low the beat is held, and the ready of other outputs has no effect.
- R6: Frames sent back to back to the same output arrive there in order, with every beat present exactly once.
- R7: When `sel` changes between back-to-back frames, the next frame goes to the new output in the cycle right after the previous frame's last beat.
- R8: Idle cycles (input valid low) inside a frame keep the destination locked.
- R9: A synchronous active-high reset clears the frame-in-progress state, so the next beat is routed by the current `sel`.
- R10: A single-beat frame (end-of-frame on its first beat) does not leave the destination locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 2 | Destination output index |
| in_data | input | 8 | Input data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_last | input | 1 | Input end-of-frame flag |
| in_user | input | 1 | Input side-band bit |
| out_data | output | 32 | Output data, output n in bits 8n+7..8n |
| out_valid | output | 4 | Per-output valid |
| out_ready | input | 4 | Per-output ready |
| out_last | output | 4 | Per-output end-of-frame |
| out_user | output | 4 | Per-output side-band bit |

## Verification
The only internal state is the busy flag and the locked index. If either is wrong, the next beat after the bad update shows valid on the wrong output or on the `sel` output in mid-frame. That fault is visible in the same combinational cycle, at most one accepted beat after the bad update. The sweep checks every beat of every frame over all destinations, frame lengths of one to four, and combinations of idle gaps, stalls and a `sel` that moves in mid-frame. A lock that fails to clear, or that clears early, therefore shows on the following beat.

// File: rtl/frame_demux.sv
module frame_demux #(
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4,
  localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SEL_W-1:0]            sel,
  input  logic [DATA_W-1:0]           in_data,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_last,
  input  logic                        in_user,
  output logic [NUM_OUT*DATA_W-1:0]   out_data,
  output logic [NUM_OUT-1:0]          out_valid,
  input  logic [NUM_OUT-1:0]          out_ready,
  output logic [NUM_OUT-1:0]          out_last,
  output logic [NUM_OUT-1:0]          out_user
);
  logic             busy_q;
  logic [SEL_W-1:0] lock_q;
  logic [SEL_W-1:0] route;
  logic             accept;

  assign route    = busy_q ? lock_q : sel;
  assign in_ready = out_ready[route];
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_port
    assign out_valid[g]                   = in_valid && (route == SEL_W'(g));
    assign out_data[g*DATA_W +: DATA_W]   = in_data;
    assign out_last[g]                    = in_last;
    assign out_user[g]                    = in_user;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      lock_q <= '0;
    end else if (accept) begin
      if (in_last) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        busy_q <= 1'b1;
        lock_q <= sel;
      end
    end
  end
endmodule

// File: rtl/frame_demux_chk.sv
module frame_demux_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4,
  localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [SEL_W-1:0]          sel,
  input logic [DATA_W-1:0]         in_data,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      in_last,
  input logic                      in_user,
  input logic [NUM_OUT*DATA_W-1:0] out_data,
  input logic [NUM_OUT-1:0]        out_valid,
  input logic [NUM_OUT-1:0]        out_ready,
  input logic [NUM_OUT-1:0]        out_last,
  input logic [NUM_OUT-1:0]        out_user
);
  logic               mid_q;
  logic [NUM_OUT-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q  <= 1'b0;
      mask_q <= '0;
    end else if (in_valid && in_ready) begin
      if (in_last) mid_q <= 1'b0;
      else if (!mid_q) begin
        mid_q  <= 1'b1;
        mask_q <= out_valid;
      end
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> out_valid == '0);
  assert_route_R1: assert property (@(posedge clk) disable iff (rst)
    (!mid_q && in_valid) |-> out_valid == (NUM_OUT'(1) << sel));
  assert_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (mid_q && in_valid) |-> out_valid == mask_q);
  assert_ready_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> in_ready == |(out_valid & out_ready));
  assert_reset_R9: assert property (@(posedge clk)
    ($past(rst) && !rst && in_valid) |-> out_valid == (NUM_OUT'(1) << sel));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pass
    assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid[g] |-> (out_data[g*DATA_W +: DATA_W] == in_data &&
                        out_last[g] == in_last && out_user[g] == in_user));
  end
endmodule

bind frame_demux frame_demux_chk #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) chk_i (
  .clk(clk), .rst(rst), .sel(sel), .in_data(in_data), .in_valid(in_valid),
  .in_ready(in_ready), .in_last(in_last), .in_user(in_user),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_user(out_user));

// File: tb/frame_demux_tb.sv
module frame_demux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  sel = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_last = 1'b0;
  logic        in_user = 1'b0;
  logic [31:0] out_data;
  logic [3:0]  out_valid;
  logic [3:0]  out_ready = '1;
  logic [3:0]  out_last;
  logic [3:0]  out_user;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_demux dut_i (
    .clk(clk), .rst(rst), .sel(sel), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .in_user(in_user),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_user(out_user));

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic beat_check(int port, logic [7:0] d, bit l, bit u, string req);
    check(out_valid == 4'(1 << port), req, 32'(out_valid), 32'(1 << port));
    check(out_data[port*8 +: 8] == d && out_last[port] == l && out_user[port] == u,
          "R3", {22'd0, out_last[port], out_user[port], out_data[port*8 +: 8]},
          {22'd0, l, u, d});
    check(in_ready == 1'b1, "R5", 32'(in_ready), 32'd1);
  endtask

  task automatic send_frame(int port, int len, bit gap, bit stall, int alt);
    for (int b = 0; b < len; b++) begin
      logic [7:0] d;
      bit l, u;
      d = 8'((port * 37 + b * 11 + len * 5) & 8'hff);
      l = (b == len - 1);
      u = (b[0] ^ port[0]);
      if (gap && b % 2 == 1) begin
        in_valid = 1'b0;
        sel = 2'(alt);
        #1;
        check(out_valid == 4'd0, "R2 R8", 32'(out_valid), 32'd0);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = d;
      in_last = l;
      in_user = u;
      sel = (b == 0) ? 2'(port) : 2'(alt);
      if (stall && b == 1) begin
        for (int s = 0; s < 2; s++) begin
          out_ready = ~(4'(1 << port));
          #1;
          check(in_ready == 1'b0, "R5", 32'(in_ready), 32'd0);
          check(out_valid == 4'(1 << port), "R4", 32'(out_valid), 32'(1 << port));
          @(negedge clk);
        end
      end
      out_ready = stall ? 4'(1 << port) : 4'hf;
      #1;
      beat_check(port, d, l, u, (b == 0) ? "R1 R6 R7 R10" : "R4 R8");
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    out_ready = 4'hf;
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 4'd0, "R2 R9", 32'(out_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int p = 0; p < 4; p++)
      for (int len = 1; len <= 4; len++)
        for (int m = 0; m < 4; m++)
          send_frame(p, len, m[0], m[1], (p + 1 + len) % 4);

    // R9: reset in mid-frame clears the lock
    in_valid = 1'b1; in_last = 1'b0; sel = 2'd2; in_data = 8'h5a;
    @(negedge clk);
    sel = 2'd3;
    #1;
    check(out_valid == 4'b0100, "R4", 32'(out_valid), 32'h4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    sel = 2'd1;
    #1;
    check(out_valid == 4'b0010, "R9", 32'(out_valid), 32'h2);
    in_valid = 1'b0;
    @(negedge clk);

    // R10: single-beat frame then immediate switch
    send_frame(3, 1, 1'b0, 1'b0, 0);
    send_frame(0, 2, 1'b0, 1'b0, 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule